// File: doc/BRIEF.md
# Packed-Vector Rounding Shift-Right and Accumulate Unit

This unit treats a 128-bit word as a packed vector of equal lanes of 8, 16, 32 or 64 bits. It shifts every lane right by an amount taken from an immediate field. Three forms are available: a plain shift, a rounding shift that adds half of the last discarded weight before shifting, and a shift whose result is added to the matching lane of a second vector. Lanes can be read as signed, which gives an arithmetic shift, or as unsigned, which gives a logical shift.

The shift amount is the lane width minus the immediate, so every amount from 1 up to the full lane width can be encoded. A shift by the full width is handled cleanly in all cases. A logical shift by the full width gives zero. An arithmetic shift by the full width fills the lane with its sign bit. A rounding shift by the full width keeps the carry of the rounding addition, because that addition is done one bit wider than the lane.

The result is registered and appears one clock after the input is presented with its valid strobe.

Top module: `vec_shr_acc`

## Requirements
- R1: The lane width is 8 << size_sel (codes 0, 1, 2 and 3 give 8, 16, 32 and 64 bits). Only the low log2(width) bits of shamt_imm are used, and the shift amount is the width minus that value, so it ranges from 1 to the width.
- R2: With is_unsigned=1, each lane is shifted right logically and zeros enter from the top.
- R3: With is_unsigned=1 and no rounding, a shift equal to the lane width gives zero.
- R4: With is_unsigned=0, each lane is shifted right arithmetically. A shift equal to the width fills the lane with copies of its sign bit.
- R5: With rnd_en=1, the value 2^(shift-1) is added to the lane before the shift. This sum is formed one bit wider than the lane, so its carry survives the shift.
- R6: A rounding shift by the full width gives the lane's top bit for unsigned lanes and gives 0 for signed lanes.
- R7: With acc_en=1, the shifted lane is added to the same lane of acc_vec. The sum wraps modulo 2^width, raises no flag and carries nothing into the next lane.
- R8: Lane i occupies bits [i*width +: width] of src_vec, acc_vec and result, and each lane is computed independently of the others.
- R9: out_valid equals in_valid delayed by exactly one clock. result carries the value computed from the inputs sampled at that clock edge.
- R10: While in_valid is low, result holds its value. Reset clears result and out_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; the inputs are captured on the rising edge while it is high |
| size_sel | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| shamt_imm | input | 6 | Immediate; shift = width - (shamt_imm mod width) |
| is_unsigned | input | 1 | 1 selects a logical shift, 0 an arithmetic shift |
| rnd_en | input | 1 | Enables the rounding addition |
| acc_en | input | 1 | Adds the shifted value to acc_vec |
| src_vec | input | 128 | Packed source vector |
| acc_vec | input | 128 | Packed accumulator vector |
| out_valid | output | 1 | High for one clock when result is new |
| result | output | 128 | Registered packed result |

## Verification
Every result is due exactly one rising edge after the input is presented. The bench drives inputs on the falling edge and reads result and out_valid on the next falling edge, half a period after the capturing edge. The following idle cycle is sampled the same way, after the source has been changed, to confirm that out_valid has dropped and that result has held its value. Expected vectors come from a bench function that works in a 67-bit signed space, so the rounding carry and the full-width shifts come out without any special cases.

// File: rtl/vsra_pkg.sv
package vsra_pkg;

  typedef struct packed {
    logic uns;
    logic rnd;
    logic acc;
  } vsra_mode_t;

  function automatic int lane_width(input int min_w, input int code);
    return min_w << code;
  endfunction

endpackage

// File: rtl/vsra_lane.sv
module vsra_lane #(
  parameter int W = 8,
  localparam int IW = $clog2(W),
  localparam int SW = IW + 1
) (
  input  logic [W-1:0]        x_i,
  input  logic [W-1:0]        a_i,
  input  logic [IW-1:0]       imm_i,
  input  vsra_pkg::vsra_mode_t mode_i,
  output logic [W-1:0]        y_o
);

  logic [SW-1:0] amt;
  logic [W:0]    x_ext;
  logic [W:0]    rnd_c;
  logic [W:0]    sum;
  logic [W-1:0]  shd;

  always_comb begin
    amt   = SW'(W) - {1'b0, imm_i};
    x_ext = mode_i.uns ? {1'b0, x_i} : {x_i[W-1], x_i};
    rnd_c = mode_i.rnd ? ((W+1)'(1) << (amt - SW'(1))) : '0;
    sum   = x_ext + rnd_c;
    if (mode_i.uns) begin
      shd = W'(sum >> amt);
    end else begin
      shd = W'($signed(sum) >>> amt);
    end
    y_o = mode_i.acc ? (a_i + shd) : shd;
  end

  // Full-width shift corner checks
  always_comb begin
    if (mode_i.uns && !mode_i.rnd && imm_i == '0) begin
      assert_flush_R3: assert (y_o == (mode_i.acc ? a_i : '0));
    end
    if (!mode_i.uns && !mode_i.rnd && !mode_i.acc && imm_i == '0) begin
      assert_signfill_R4: assert (y_o == {W{x_i[W-1]}});
    end
    if (mode_i.uns && mode_i.rnd && !mode_i.acc && imm_i == '0) begin
      assert_rndcarry_R6: assert (y_o == W'(x_i[W-1]));
    end
  end

endmodule

// File: rtl/vsra_lane_array.sv
module vsra_lane_array #(
  parameter int VEC_W = 128,
  parameter int W     = 8,
  localparam int NL   = VEC_W / W,
  localparam int IW   = $clog2(W)
) (
  input  logic [VEC_W-1:0]     src_i,
  input  logic [VEC_W-1:0]     acc_i,
  input  logic [IW-1:0]        imm_i,
  input  vsra_pkg::vsra_mode_t mode_i,
  output logic [VEC_W-1:0]     res_o
);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    vsra_lane #(.W(W)) u_lane (
      .x_i   (src_i[l*W +: W]),
      .a_i   (acc_i[l*W +: W]),
      .imm_i (imm_i),
      .mode_i(mode_i),
      .y_o   (res_o[l*W +: W])
    );
  end

endmodule

// File: rtl/vec_shr_acc.sv
module vec_shr_acc #(
  parameter int VEC_W      = 128,
  parameter int MIN_LANE_W = 8,
  parameter int NUM_SIZES  = 4,
  localparam int SEL_W     = $clog2(NUM_SIZES),
  localparam int MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1),
  localparam int IMM_W     = $clog2(MAX_LANE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SEL_W-1:0] size_sel,
  input  logic [IMM_W-1:0] shamt_imm,
  input  logic             is_unsigned,
  input  logic             rnd_en,
  input  logic             acc_en,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] acc_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);

  import vsra_pkg::*;

  vsra_mode_t       mode;
  logic [VEC_W-1:0] by_size [NUM_SIZES];
  logic [VEC_W-1:0] sel_res;
  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;

  assign mode = '{uns: is_unsigned, rnd: rnd_en, acc: acc_en};

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int LW  = lane_width(MIN_LANE_W, g);
    localparam int LIW = $clog2(LW);
    vsra_lane_array #(.VEC_W(VEC_W), .W(LW)) u_arr (
      .src_i (src_vec),
      .acc_i (acc_vec),
      .imm_i (shamt_imm[LIW-1:0]),
      .mode_i(mode),
      .res_o (by_size[g])
    );
  end

  always_comb begin
    sel_res = by_size[size_sel];
    res_d   = in_valid ? sel_res : res_q;
    vld_d   = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result    = res_q;
  assign out_valid = vld_q;

  assert_valid_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

endmodule

// File: tb/vec_shr_acc_bench.sv
module vec_shr_acc_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   size_sel;
  logic [5:0]   shamt_imm;
  logic         is_unsigned, rnd_en, acc_en;
  logic [127:0] src_vec, acc_vec;
  logic         out_valid;
  logic [127:0] result;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  vec_shr_acc u_vec_shr_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
    .shamt_imm(shamt_imm), .is_unsigned(is_unsigned), .rnd_en(rnd_en),
    .acc_en(acc_en), .src_vec(src_vec), .acc_vec(acc_vec),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] model(input int sz, input int immv, input bit uns,
                                          input bit rnd, input bit ac,
                                          input logic [127:0] s, input logic [127:0] a);
    int w  = 8 << sz;
    int sh = w - (immv % w);
    logic [127:0] out = '0;
    logic [63:0]  mask = {64{1'b1}} >> (64 - w);
    for (int l = 0; l < 128 / w; l++) begin
      logic [63:0] xl = 64'(s >> (l * w)) & mask;
      logic [63:0] al = 64'(a >> (l * w)) & mask;
      logic signed [66:0] v = $signed({3'b000, xl});
      logic [63:0] r;
      if (!uns && xl[w-1]) v = v - (67'sd1 <<< w);
      if (rnd) v = v + (67'sd1 <<< (sh - 1));
      v = v >>> sh;
      r = v[63:0];
      if (ac) r = r + al;
      r = r & mask;
      out = out | (128'(r) << (l * w));
    end
    return out;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input int sz, input int immv, input bit uns,
                       input bit rnd, input bit ac, input logic [127:0] s,
                       input logic [127:0] a);
    logic [127:0] exp = model(sz, immv, uns, rnd, ac, s, a);
    @(negedge clk);
    in_valid = 1'b1; size_sel = 2'(sz); shamt_imm = 6'(immv);
    is_unsigned = uns; rnd_en = rnd; acc_en = ac; src_vec = s; acc_vec = a;
    @(negedge clk);
    check({req, " R9 valid"}, {127'd0, out_valid}, 128'd1);
    check(req, result, exp);
    in_valid = 1'b0;
    src_vec = ~s;
    @(negedge clk);
    check("R9 idle valid", {127'd0, out_valid}, 128'd0);
    check("R10 hold", result, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; in_valid = 1'b0; size_sel = '0; shamt_imm = '0;
    is_unsigned = 1'b0; rnd_en = 1'b0; acc_en = 1'b0; src_vec = '0; acc_vec = '0;
    repeat (3) @(negedge clk);
    check("R10 reset result", result, '0);
    check("R10 reset valid", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;

    // R3: unsigned full-width shift flushes to zero
    apply("R3 flush", 0, 0, 1, 0, 0, {16{8'hFF}}, '0);
    // R4: signed full-width shift fills the sign
    apply("R4 signfill", 0, 0, 0, 0, 0, {8{8'h80, 8'h7F}}, '0);
    check("R4 literal", result, {8{8'hFF, 8'h00}});
    // R6: rounding at full width keeps the carry
    apply("R6 rnd unsigned", 1, 0, 1, 1, 0, {4{16'h8000, 16'h7FFF}}, '0);
    check("R6 literal", result, {4{16'h0001, 16'h0000}});
    apply("R6 rnd signed", 2, 0, 0, 1, 0, {2{32'h8000_0000, 32'h7FFF_FFFF}}, '0);
    // R5: rounding at 64 bits with a carry out of the lane
    apply("R5 rnd carry", 3, 1, 1, 1, 0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0);
    // R7: accumulate wraps inside the lane: 0xFF + (0x02>>1) = 0x00
    apply("R7 wrap", 0, 7, 1, 0, 1, {16{8'h02}}, {16{8'hFF}});
    check("R7 literal", result, '0);
    // R1: imm 9 on 8-bit lanes uses 9 mod 8 = 1, shift 7
    apply("R1 imm mod", 0, 9, 1, 0, 0, {16{8'hC0}}, '0);
    check("R1 literal", result, {16{8'h01}});
    // R2 / R8: distinct lanes with a logical shift
    apply("R2 R8 lanes", 3, 60, 1, 0, 0, {64'hF000_0000_0000_0010, 64'h0000_0000_0000_0100}, '0);
    check("R8 literal", result, {64'h0F00_0000_0000_0001, 64'h0000_0000_0000_0010});

    for (int i = 0; i < 400; i++) begin
      int sz = $urandom_range(3, 0);
      apply("R1 R2 R4 R5 R7 R8 random", sz, $urandom_range(63, 0), 1'($urandom),
            1'($urandom), 1'($urandom),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom});
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule